// File: doc/BRIEF.md
# Selectable Wake Interrupt Source

This block produces the request for a single external interrupt line of a microcontroller. A source-select bit chooses what drives the request. One option is a dedicated wake pin. The other is the OR of all bits of an eight-bit input port. The port source is qualified by a programmable hold time, counted in millisecond ticks. A short glitch on any port bit therefore cannot raise the request.

The block also owns the processor's idle flag. Software sets the flag through a request strobe. Only the interrupt can clear it, and only after the request has stayed high without a break for a minimum time. That time stands for a 400 µs qualification window and is counted in clock cycles. The CPU interrupt controller and the clock gating that the idle flag drives lie outside the block.

Every interface of the block is a control or status pin. None carries a data stream, so there is no valid/ready handshake and no back-pressure. Register writes take effect on the clock edge where their strobe is sampled high.

Top module: `wkirq_top`

## Requirements
- R1: With the source-select bit at 0, `irq_req` equals the level of `ext_pin` captured two clock edges earlier, through a two-flop synchronizer. A high level means a request.
- R2: With the source-select bit at 1, `irq_req` is high only while at least one bit of the synchronized `port_in` is high and the delay qualification of R6 has been met.
- R3: The delay field is the low four bits of the delay register. It resets to binary 0010 (2 ms). `dly_rdata[3:0]` returns the value written through `dly_wr`/`dly_wdata[3:0]` from the next cycle on.
- R4: Bits 7 to 4 of the delay register are reserved. Writes to them have no effect, and they always read back as 0 on `dly_rdata[7:4]`.
- R5: The source-select bit resets to 0, which selects the pin. A `sel_wr` pulse loads `sel_wdata`, and the new source drives `irq_req` from the next cycle on.
- R6: The port delay counter restarts at 0 whenever the ORed port input is low. It advances by one on each `ms_tick` while the ORed input is high. The port source is qualified once the count reaches the delay value. A delay value of 0 qualifies at once.
- R7: `idle_flag` resets to 0 and is set by an `idle_set` pulse. It is cleared only by a qualified interrupt (R8). If a clear and a set fall in the same cycle, the clear wins.
- R8: `idle_flag` clears in the cycle where `irq_req` has been high for QUAL_CYCLES consecutive edges. A request that drops before that leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond, synchronous to clk |
| ext_pin | input | 1 | Dedicated wake pin, asynchronous, active high |
| port_in | input | 8 | Asynchronous input port, ORed when selected |
| sel_wr | input | 1 | Write strobe for the source-select bit |
| sel_wdata | input | 1 | Source select: 0 = pin, 1 = port OR |
| dly_wr | input | 1 | Write strobe for the delay register |
| dly_wdata | input | 8 | Delay register write data; only bits 3:0 are stored |
| idle_set | input | 1 | Request to enter idle (sets the idle flag) |
| irq_req | output | 1 | Interrupt request to the CPU |
| idle_flag | output | 1 | Idle-mode flag |
| dly_rdata | output | 8 | Delay register read-back, bits 7:4 read as 0 |

## Verification
Some rules are checked on every cycle by properties. The pin path is checked as a two-cycle delay of `ext_pin`. The delay counter must return to zero after the port OR goes low, and it must hold between ticks. The idle flag may fall only when a qualified request is present, and an idle request with no clear in the same cycle must set the flag. Other behaviour shows only in the bench's scenarios, which a cycle model checks every clock: the delay value reached in milliseconds, a restart after the port drops part-way, the zero-delay case, a short pin pulse that fails to wake, a clear that collides with a set, and a write to the reserved bits.

// File: rtl/wkirq_pkg.sv
package wkirq_pkg;
  typedef enum logic {
    SRC_PIN  = 1'b0,
    SRC_PORT = 1'b1
  } src_sel_e;

  localparam int SYNC_DEPTH = 2;
  localparam logic [3:0] DLY_RESET = 4'b0010;
endpackage

// File: rtl/wkirq_sync.sv
module wkirq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wkirq_port_qual.sv
module wkirq_port_qual #(
  parameter int PORT_W = 8,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [PORT_W-1:0] port_s,
  input  logic [DLY_W-1:0]  dly,
  output logic              port_any,
  output logic              port_qual
);
  logic [DLY_W-1:0] cnt;

  assign port_any = |port_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!port_any)         cnt <= '0;
    else if (tick && cnt < dly) cnt <= cnt + 1'b1;
  end

  assign port_qual = port_any && (cnt >= dly);

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !port_any |=> (cnt == '0));

  p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_any && !tick) |=> $stable(cnt));
endmodule

// File: rtl/wkirq_idle_ctl.sv
module wkirq_idle_ctl #(
  parameter int QUAL_CYCLES = 4800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic idle_set,
  output logic idle,
  output logic wake
);
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [QW-1:0] QMAX  = QW'(QUAL_CYCLES);
  localparam logic [QW-1:0] QLAST = QW'(QUAL_CYCLES - 1);

  logic [QW-1:0] qcnt;
  logic          clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           qcnt <= '0;
    else if (!irq)        qcnt <= '0;
    else if (qcnt < QMAX) qcnt <= qcnt + 1'b1;
  end

  assign wake = (qcnt == QMAX);
  assign clr  = irq && (qcnt == QLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idle <= 1'b0;
    else if (clr)      idle <= 1'b0;
    else if (idle_set) idle <= 1'b1;
  end

  p_clear_only_by_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> wake);

  p_set_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_set && !clr) |=> idle);

  p_wake_needs_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake) |-> $past(irq));
endmodule

// File: rtl/wkirq_top.sv
module wkirq_top
  import wkirq_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int DLY_W       = 4,
  parameter int CFG_W       = 8,
  parameter int QUAL_CYCLES = 4800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_in,
  input  logic              sel_wr,
  input  logic              sel_wdata,
  input  logic              dly_wr,
  input  logic [CFG_W-1:0]  dly_wdata,
  input  logic              idle_set,
  output logic              irq_req,
  output logic              idle_flag,
  output logic [CFG_W-1:0]  dly_rdata
);
  localparam int RSV_W = CFG_W - DLY_W;

  src_sel_e          src_sel;
  logic [DLY_W-1:0]  dly_q;
  logic              pin_s;
  logic [PORT_W-1:0] port_s;
  logic              port_any;
  logic              port_qual;
  logic              wake;
  logic              unused_rsvd;

  assign unused_rsvd = ^dly_wdata[CFG_W-1:DLY_W] ^ port_any ^ wake;

  wkirq_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(pin_s)
  );

  wkirq_sync #(.W(PORT_W), .STAGES(SYNC_DEPTH)) u_port_sync (
    .clk(clk), .rst_n(rst_n), .d(port_in), .q(port_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel <= SRC_PIN;
      dly_q   <= DLY_RESET[DLY_W-1:0];
    end else begin
      if (sel_wr) src_sel <= src_sel_e'(sel_wdata);
      if (dly_wr) dly_q   <= dly_wdata[DLY_W-1:0];
    end
  end

  assign dly_rdata = {{RSV_W{1'b0}}, dly_q};

  wkirq_port_qual #(.PORT_W(PORT_W), .DLY_W(DLY_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .port_s(port_s), .dly(dly_q),
    .port_any(port_any), .port_qual(port_qual)
  );

  assign irq_req = (src_sel == SRC_PORT) ? port_qual : pin_s;

  wkirq_idle_ctl #(.QUAL_CYCLES(QUAL_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .irq(irq_req), .idle_set(idle_set),
    .idle(idle_flag), .wake(wake)
  );

  logic [1:0] settle;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              settle <= '0;
    else if (settle != 2'd3) settle <= settle + 2'd1;
  end

  p_pin_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (settle == 2'd3 && src_sel == SRC_PIN) |-> (irq_req == $past(ext_pin, 2)));

  p_port_low_no_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (settle == 2'd3 && src_sel == SRC_PORT && $past(port_in, 2) == '0)
      |-> !irq_req);
endmodule

// File: tb/wkirq_top_test.sv
`timescale 1ns/1ps
module wkirq_top_test;
  localparam int QUAL = 12;
  localparam int TICK_EVERY = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       ext_pin = 1'b0;
  logic [7:0] port_in = '0;
  logic       sel_wr = 1'b0, sel_wdata = 1'b0;
  logic       dly_wr = 1'b0;
  logic [7:0] dly_wdata = '0;
  logic       idle_set = 1'b0;
  logic       irq_req, idle_flag;
  logic [7:0] dly_rdata;

  wkirq_top #(.QUAL_CYCLES(QUAL)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ext_pin(ext_pin),
    .port_in(port_in), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .dly_wr(dly_wr), .dly_wdata(dly_wdata), .idle_set(idle_set),
    .irq_req(irq_req), .idle_flag(idle_flag), .dly_rdata(dly_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int       pin_q[$];
  int       port_q[$];
  bit       m_sel;
  int       m_dly, m_cnt, m_hold;
  bit       m_idle;

  function automatic bit m_irq();
    if (m_sel) return (port_q[1] != 0) && (m_cnt >= m_dly);
    return pin_q[1] != 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pin_q = '{0, 0};
      port_q = '{0, 0};
      m_sel = 0; m_dly = 2; m_cnt = 0; m_hold = 0; m_idle = 0;
    end else begin
      bit ir;
      ir = m_irq();
      if (ir && m_hold == QUAL - 1) m_idle = 0;
      else if (idle_set)            m_idle = 1;
      if (!ir)             m_hold = 0;
      else if (m_hold < QUAL) m_hold++;
      if (port_q[1] == 0)               m_cnt = 0;
      else if (ms_tick && m_cnt < m_dly) m_cnt++;
      if (sel_wr) m_sel = sel_wdata;
      if (dly_wr) m_dly = dly_wdata[3:0];
      void'(pin_q.pop_back());  pin_q.push_front(int'(ext_pin));
      void'(port_q.pop_back()); port_q.push_front(int'(port_in));
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(m_sel ? "R2" : "R1", int'(irq_req), int'(m_irq()));
      chk("R7", int'(idle_flag), int'(m_idle));
      chk("R3", int'(dly_rdata), m_dly);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_sel(input bit v);
    sel_wdata = v; sel_wr = 1'b1; cyc(1); sel_wr = 1'b0;
  endtask

  task automatic wr_dly(input logic [7:0] v);
    dly_wdata = v; dly_wr = 1'b1; cyc(1); dly_wr = 1'b0;
  endtask

  task automatic set_idle();
    idle_set = 1'b1; cyc(1); idle_set = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int tc = 0;
    fork
      forever begin
        @(negedge clk);
        tc++;
        ms_tick = (tc % TICK_EVERY == 0);
      end
    join_none

    cyc(3);
    rst_n = 1'b1;
    port_in = 8'h40;
    cyc(4);
    chk("R3", int'(dly_rdata), 2);
    chk("R5", int'(irq_req), 0);
    chk("R7", int'(idle_flag), 0);

    // R1: pin path, two-cycle latency
    ext_pin = 1'b1; cyc(1);
    chk("R1", int'(irq_req), 0);
    cyc(1);
    chk("R1", int'(irq_req), 1);
    ext_pin = 1'b0; cyc(3);
    chk("R1", int'(irq_req), 0);

    // R8: short pulse does not clear idle
    set_idle(); cyc(1);
    chk("R7", int'(idle_flag), 1);
    ext_pin = 1'b1; cyc(4); ext_pin = 1'b0; cyc(6);
    chk("R8", int'(idle_flag), 1);
    // long hold clears idle
    ext_pin = 1'b1; cyc(QUAL + 4);
    chk("R8", int'(idle_flag), 0);
    // set while held (already qualified) stays set
    set_idle(); cyc(1);
    chk("R7", int'(idle_flag), 1);
    ext_pin = 1'b0; cyc(4);
    // set colliding with clear: clear wins
    ext_pin = 1'b1; cyc(QUAL + 1);
    idle_set = 1'b1; cyc(3); idle_set = 1'b0; cyc(1);
    ext_pin = 1'b0; cyc(4);

    // R4: reserved bits
    wr_dly(8'hF5); cyc(1);
    chk("R4", int'(dly_rdata), 5);
    chk("R4", int'(dly_rdata[7:4]), 0);

    // R5 / R2 / R6: port source with 3 ms delay
    port_in = 8'h00; wr_dly(8'h03);
    wr_sel(1'b1); cyc(1);
    chk("R5", int'(irq_req), 0);
    port_in = 8'h08; cyc(TICK_EVERY);
    chk("R6", int'(irq_req), 0);
    cyc(4 * TICK_EVERY);
    chk("R2", int'(irq_req), 1);
    port_in = 8'h00; cyc(4);
    chk("R2", int'(irq_req), 0);
    // restart: drop part-way
    port_in = 8'h81; cyc(2 * TICK_EVERY);
    port_in = 8'h00; cyc(3);
    port_in = 8'h02; cyc(TICK_EVERY + 2);
    chk("R6", int'(irq_req), 0);
    cyc(3 * TICK_EVERY);
    chk("R6", int'(irq_req), 1);
    // pin is ignored while the port is selected
    port_in = 8'h00; ext_pin = 1'b1; cyc(4);
    chk("R5", int'(irq_req), 0);
    ext_pin = 1'b0;

    // R6: zero delay qualifies at once
    wr_dly(8'h00);
    port_in = 8'h10; cyc(2);
    chk("R6", int'(irq_req), 1);
    set_idle(); cyc(QUAL + 2);
    chk("R8", int'(idle_flag), 0);
    port_in = 8'h00; cyc(3);

    // back to pin
    wr_sel(1'b0); ext_pin = 1'b1; cyc(3);
    chk("R5", int'(irq_req), 1);
    ext_pin = 1'b0; cyc(4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule